// File: doc/BRIEF.md
# Parallel NOR Flash Identification Sequencer

This block reads the identity of a byte-wide parallel NOR flash without software stepping it through the command protocol. After a start pulse it issues its bus cycles one at a time on a simple request/acknowledge interface. The first cycles are a reset. The next is the three-write unlock that puts the chip into identification mode. It then reads the manufacturer and device bytes. If either byte is the continuation code, it reads a second byte for that ID. It then returns the chip to array mode and reads the same locations again.

The block compares the two IDs it has assembled against expected values supplied on its inputs. It also checks that the manufacturer byte has odd parity. For each ID it reports whether the value equals what the chip returns after leaving identification mode. When that happens, the chip probably never entered the mode and the "ID" is ordinary array data.

Options are latched at start:
- an address-shifted variant,
- three address masks,
- a longer reset that repeats the unlock writes before the reset command,
- three timing modes. The settle delays are counted in clock cycles.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is asserted and after it is released, `bus_req`, `busy` and `done` are low and `id_man` and `id_dev` read zero.
- R2: Command writes use address A1 for the first and third unlock writes and for the reset write, and A2 for the second unlock write. A1 is 0x5555 and A2 is 0x2AAA, or the other way round when `cfg_shifted` is 1. Both are ANDed with the mask picked by `cfg_mask_sel`: 0 gives 0xFFFF, 1 gives 0x07FF, 2 gives 0x0FFF and 3 gives 0xFFFF.
- R3: The bus cycles come in this order, one at a time:
  - for the reset: (0xAA@A1, 0x55@A2 only when `cfg_long_reset` is 1), then 0xF0@A1;
  - for entry: 0xAA@A1, 0x55@A2, 0x90@A1;
  - reads at 0 and at 1 (2 when shifted), then 0x100 if the first byte was 0x7F, then 0x101 if the second byte was 0x7F;
  - the same reset group again as the exit;
  - the same reads again, with the continuation rule applied to the new bytes.
- R4: An ID whose first byte is 0x7F becomes {0x7F, byte read at 0x100 (manufacturer) or 0x101 (device)}. Otherwise it is {0x00, byte}. Only one extension is done, even when the second byte is also 0x7F.
- R5: With a responder that answers one cycle after a request, the acknowledge-to-acknowledge spacing after a write follows that write's delay d: d+2 cycles.
  - After each 0xF0 write, d is the exit delay.
  - After 0x90, d is the entry delay.
  - After an entry unlock write, d is GAP_CYC when the entry delay is nonzero and 0 otherwise.
  - After a reset or exit unlock write, d is GAP_CYC when the exit delay is nonzero and 0 otherwise.
  - An entry delay also comes before the first command: the first acknowledge comes entry+3 cycles after the start edge with the long reset, and entry+5 cycles after it without.
- R6: `cfg_tmode` sets the delays as follows:
  - 0 and 3 use the parameter defaults ENT_DEF and EXT_DEF;
  - 1 sets both delays to zero;
  - 2 sets both to `cfg_tval`.
- R7: `parity_err` is 1 when the last manufacturer byte read during identification mode has an even number of ones.
- R8: `id_match` is 1 exactly when `id_man` equals `exp_man` and `id_dev` equals `exp_dev`.
- R9: `man_is_array` and `dev_is_array` are 1 when the corresponding ID equals the value assembled from the reads after exit.
- R10: `done` is high for exactly one cycle when the results are valid. At that point `busy` is low. The result outputs then hold until the next start.
- R11: A start pulse while `busy` is high is ignored: no extra bus cycles and no second `done`.
- R12: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged. `bus_req` is only high while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (accepted when idle) |
| cfg_shifted | input | 1 | Swap command addresses and double the ID read offset |
| cfg_mask_sel | input | 2 | Command address mask select |
| cfg_long_reset | input | 1 | Prefix reset/exit with unlock writes |
| cfg_tmode | input | 2 | Delay mode: default, none, or from cfg_tval |
| cfg_tval | input | DLY_W | Delay in cycles for mode 2 |
| exp_man | input | 16 | Expected manufacturer ID |
| exp_dev | input | 16 | Expected device ID |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 16 | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Cycle completed (read data valid) |
| bus_rdata | input | 8 | Read data |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| id_man | output | 16 | Assembled manufacturer ID |
| id_dev | output | 16 | Assembled device ID |
| id_match | output | 1 | Both IDs equal the expected values |
| parity_err | output | 1 | Manufacturer byte lacks odd parity |
| man_is_array | output | 1 | Manufacturer ID equals post-exit read |
| dev_is_array | output | 1 | Device ID equals post-exit read |

## Verification
The bench drives a behavioural flash model with five option sets. These cover continuation on both IDs, a continuation that returns 0x7F again, the shifted layout with a narrow mask, and both zero and custom delays. For each set it compares the logged bus trace and its spacing with a sequence it derives itself.

Each corner case targets a specific fault:
- A design that used the wrong unlock address or mask would never reach identification mode, so its IDs would come out as array data.
- A design that looped on continuation codes, or that read the extension too early, would show extra or misplaced reads.
- A design that kept the unlock gaps in zero-delay mode would stretch the trace.
- A run with a second start pulse in mid-probe shows whether a restart would double the trace.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_WR   = 2'd1,
    ACT_RD   = 2'd2
  } act_e;

  // Order of steps is the bus order; skipped steps cost one cycle each.
  typedef enum logic [4:0] {
    S_PRE    = 5'd0,
    S_RST_AA = 5'd1,
    S_RST_55 = 5'd2,
    S_RST_F0 = 5'd3,
    S_ENT_AA = 5'd4,
    S_ENT_55 = 5'd5,
    S_ENT_90 = 5'd6,
    S_ID0    = 5'd7,
    S_ID1    = 5'd8,
    S_ID0X   = 5'd9,
    S_ID1X   = 5'd10,
    S_EX_AA  = 5'd11,
    S_EX_55  = 5'd12,
    S_EX_F0  = 5'd13,
    S_AR0    = 5'd14,
    S_AR1    = 5'd15,
    S_AR0X   = 5'd16,
    S_AR1X   = 5'd17,
    S_FIN    = 5'd18
  } step_e;

  typedef enum logic [1:0] {
    P_IDLE  = 2'd0,
    P_ISSUE = 2'd1,
    P_WAIT  = 2'd2
  } phase_e;

  localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLK_B = 8'h55;
  localparam logic [7:0]  CMD_IDENT  = 8'h90;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
  localparam logic [7:0]  CONT_CODE  = 8'h7F;
  localparam logic [15:0] ADR_ODD    = 16'h5555;
  localparam logic [15:0] ADR_EVEN   = 16'h2AAA;
  localparam logic [15:0] EXT_ADR_M  = 16'h0100;
  localparam logic [15:0] EXT_ADR_D  = 16'h0101;

endpackage

// File: rtl/fid_step_decode.sv
module fid_step_decode
  import flash_id_pkg::*;
#(
  parameter int DW      = 24,
  parameter int GAP_CYC = 500
) (
  input  step_e          step,
  input  logic           shifted,
  input  logic [1:0]     mask_sel,
  input  logic           long_rst,
  input  logic [DW-1:0]  dly_ent,
  input  logic [DW-1:0]  dly_ext,
  input  logic           id0_cont,
  input  logic           id1_cont,
  input  logic           ar0_cont,
  input  logic           ar1_cont,
  output act_e           act,
  output logic [15:0]    addr,
  output logic [7:0]     wdata,
  output logic [DW-1:0]  post
);

  localparam logic [DW-1:0] GAP = DW'(GAP_CYC);

  logic [15:0]   mask;
  logic [15:0]   a_first;
  logic [15:0]   a_second;
  logic [15:0]   off_dev;
  logic [DW-1:0] gap_ent;
  logic [DW-1:0] gap_ext;

  always_comb begin
    case (mask_sel)
      2'd1:    mask = 16'h07FF;
      2'd2:    mask = 16'h0FFF;
      default: mask = 16'hFFFF;
    endcase
    a_first  = (shifted ? ADR_EVEN : ADR_ODD) & mask;
    a_second = (shifted ? ADR_ODD : ADR_EVEN) & mask;
    off_dev  = shifted ? 16'd2 : 16'd1;
    gap_ent  = (dly_ent != '0) ? GAP : '0;
    gap_ext  = (dly_ext != '0) ? GAP : '0;
  end

  always_comb begin
    act   = ACT_NONE;
    addr  = 16'h0000;
    wdata = 8'h00;
    post  = '0;
    case (step)
      S_PRE: post = dly_ent;
      S_RST_AA, S_EX_AA: if (long_rst) begin
        act = ACT_WR; addr = a_first; wdata = CMD_UNLK_A; post = gap_ext;
      end
      S_RST_55, S_EX_55: if (long_rst) begin
        act = ACT_WR; addr = a_second; wdata = CMD_UNLK_B; post = gap_ext;
      end
      S_RST_F0, S_EX_F0: begin
        act = ACT_WR; addr = a_first; wdata = CMD_RESET; post = dly_ext;
      end
      S_ENT_AA: begin
        act = ACT_WR; addr = a_first; wdata = CMD_UNLK_A; post = gap_ent;
      end
      S_ENT_55: begin
        act = ACT_WR; addr = a_second; wdata = CMD_UNLK_B; post = gap_ent;
      end
      S_ENT_90: begin
        act = ACT_WR; addr = a_first; wdata = CMD_IDENT; post = dly_ent;
      end
      S_ID0, S_AR0: begin act = ACT_RD; addr = 16'h0000; end
      S_ID1, S_AR1: begin act = ACT_RD; addr = off_dev; end
      S_ID0X: if (id0_cont) begin act = ACT_RD; addr = EXT_ADR_M; end
      S_ID1X: if (id1_cont) begin act = ACT_RD; addr = EXT_ADR_D; end
      S_AR0X: if (ar0_cont) begin act = ACT_RD; addr = EXT_ADR_M; end
      S_AR1X: if (ar1_cont) begin act = ACT_RD; addr = EXT_ADR_D; end
      default: ;
    endcase
  end

endmodule

// File: rtl/fid_delay_timer.sv
module fid_delay_timer #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          last
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == DW'(1));

endmodule

// File: rtl/fid_id_capture.sv
module fid_id_capture
  import flash_id_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  step_e       step,
  input  logic [7:0]  rdata,
  output logic [15:0] man_id,
  output logic [15:0] dev_id,
  output logic [15:0] man_arr,
  output logic [15:0] dev_arr
);

  logic [15:0] man_d, dev_d, marr_d, darr_d;

  always_comb begin
    man_d  = man_id;
    dev_d  = dev_id;
    marr_d = man_arr;
    darr_d = dev_arr;
    if (clr) begin
      man_d = '0; dev_d = '0; marr_d = '0; darr_d = '0;
    end else if (en) begin
      case (step)
        S_ID0:  man_d  = {8'h00, rdata};
        S_ID1:  dev_d  = {8'h00, rdata};
        S_ID0X: man_d  = {man_id[7:0], rdata};
        S_ID1X: dev_d  = {dev_id[7:0], rdata};
        S_AR0:  marr_d = {8'h00, rdata};
        S_AR1:  darr_d = {8'h00, rdata};
        S_AR0X: marr_d = {man_arr[7:0], rdata};
        S_AR1X: darr_d = {dev_arr[7:0], rdata};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_id  <= '0;
      dev_id  <= '0;
      man_arr <= '0;
      dev_arr <= '0;
    end else begin
      man_id  <= man_d;
      dev_id  <= dev_d;
      man_arr <= marr_d;
      dev_arr <= darr_d;
    end
  end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_pkg::*;
#(
  parameter int DLY_W   = 24,
  parameter int ENT_DEF = 500000,
  parameter int EXT_DEF = 2000,
  parameter int GAP_CYC = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_shifted,
  input  logic [1:0]       cfg_mask_sel,
  input  logic             cfg_long_reset,
  input  logic [1:0]       cfg_tmode,
  input  logic [DLY_W-1:0] cfg_tval,
  input  logic [15:0]      exp_man,
  input  logic [15:0]      exp_dev,
  output logic             bus_req,
  output logic             bus_we,
  output logic [15:0]      bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      id_man,
  output logic [15:0]      id_dev,
  output logic             id_match,
  output logic             parity_err,
  output logic             man_is_array,
  output logic             dev_is_array
);

  localparam int DW = DLY_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  phase_e        phase_q, phase_d;
  step_e         step_q, step_d;
  logic          done_q, done_d;
  logic          sh_q, long_q;
  logic [1:0]    msel_q;
  logic [DW-1:0] ent_q, ext_q, ent_sel, ext_sel;
  logic          latch, clr, load, cap_en, tmr_last;
  act_e          act;
  logic [15:0]   addr;
  logic [7:0]    wdata;
  logic [DW-1:0] post;
  logic [15:0]   man_arr, dev_arr;

  always_comb begin
    case (cfg_tmode)
      2'd1:    begin ent_sel = '0;       ext_sel = '0;       end
      2'd2:    begin ent_sel = cfg_tval; ext_sel = cfg_tval; end
      default: begin ent_sel = DW'(ENT_DEF); ext_sel = DW'(EXT_DEF); end
    endcase
  end

  fid_step_decode #(.DW(DW), .GAP_CYC(GAP_CYC)) u_dec (
    .step     (step_q),
    .shifted  (sh_q),
    .mask_sel (msel_q),
    .long_rst (long_q),
    .dly_ent  (ent_q),
    .dly_ext  (ext_q),
    .id0_cont (id_man[7:0] == CONT_CODE),
    .id1_cont (id_dev[7:0] == CONT_CODE),
    .ar0_cont (man_arr[7:0] == CONT_CODE),
    .ar1_cont (dev_arr[7:0] == CONT_CODE),
    .act      (act),
    .addr     (addr),
    .wdata    (wdata),
    .post     (post)
  );

  fid_delay_timer #(.DW(DW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (load),
    .load_val (post),
    .last     (tmr_last)
  );

  fid_id_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clr     (clr),
    .en      (cap_en),
    .step    (step_q),
    .rdata   (bus_rdata),
    .man_id  (id_man),
    .dev_id  (id_dev),
    .man_arr (man_arr),
    .dev_arr (dev_arr)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    done_d  = 1'b0;
    latch   = 1'b0;
    clr     = 1'b0;
    load    = 1'b0;
    cap_en  = 1'b0;
    case (phase_q)
      P_IDLE: if (start) begin
        latch   = 1'b1;
        clr     = 1'b1;
        step_d  = S_PRE;
        phase_d = P_ISSUE;
      end
      P_ISSUE: begin
        if (step_q == S_FIN) begin
          phase_d = P_IDLE;
          done_d  = 1'b1;
        end else if (act == ACT_NONE || bus_ack) begin
          cap_en = (act == ACT_RD);
          if (post == '0) begin
            step_d = step_e'(step_q + 5'd1);
          end else begin
            load    = 1'b1;
            phase_d = P_WAIT;
          end
        end
      end
      P_WAIT: if (tmr_last) begin
        step_d  = step_e'(step_q + 5'd1);
        phase_d = P_ISSUE;
      end
      default: phase_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= P_IDLE;
      step_q  <= S_PRE;
      done_q  <= 1'b0;
      sh_q    <= 1'b0;
      long_q  <= 1'b0;
      msel_q  <= 2'd0;
      ent_q   <= '0;
      ext_q   <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done_q  <= done_d;
      if (latch) begin
        sh_q   <= cfg_shifted;
        long_q <= cfg_long_reset;
        msel_q <= cfg_mask_sel;
        ent_q  <= ent_sel;
        ext_q  <= ext_sel;
      end
    end
  end

  assign bus_req      = (phase_q == P_ISSUE) && (act != ACT_NONE);
  assign bus_we       = (act == ACT_WR);
  assign bus_addr     = addr;
  assign bus_wdata    = wdata;
  assign busy         = (phase_q != P_IDLE);
  assign done         = done_q;
  assign id_match     = (id_man == exp_man) && (id_dev == exp_dev);
  assign parity_err   = ~(^id_man[7:0]);
  assign man_is_array = (id_man == man_arr);
  assign dev_is_array = (id_dev == dev_arr);

endmodule

// File: rtl/fid_probe_chk.sv
module fid_probe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        busy,
  input logic        done,
  input logic [15:0] id_man
);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                             && $stable(bus_wdata));

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_req);

  p_cmd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> (bus_wdata == 8'hAA || bus_wdata == 8'h55 ||
                           bus_wdata == 8'h90 || bus_wdata == 8'hF0));

  p_read_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> (bus_addr == 16'h0000 || bus_addr == 16'h0001 ||
                            bus_addr == 16'h0002 || bus_addr == 16'h0100 ||
                            bus_addr == 16'h0101));

  p_cont_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (id_man[15:8] != 8'h00) |-> id_man[15:8] == 8'h7F);

endmodule

bind flash_id_probe fid_probe_chk u_fid_probe_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .busy      (busy),
  .done      (done),
  .id_man    (id_man)
);

// File: tb/flash_id_probe_bench.sv
module flash_id_probe_bench;

  localparam int ENT = 40;
  localparam int EXT = 12;
  localparam int GAP = 4;
  localparam int DW  = 24;
  localparam int NV  = 5;
  localparam int LGN = 256;

  typedef struct packed {
    logic        sh;
    logic [1:0]  ms;
    logic        lg;
    logic [1:0]  tm;
    logic [7:0]  tv;
    logic [7:0]  i0, i1, c0, c1;
    logic [7:0]  a0, a1, a100, a101;
    logic [15:0] em, ed;
    logic [15:0] xm, xd;
    logic        xmatch, xpar, xma, xda;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{1'b0, 2'd0, 1'b0, 2'd1, 8'd0, 8'hBF, 8'h34, 8'h00, 8'h00,
      8'h11, 8'h22, 8'h00, 8'h00, 16'h00BF, 16'h0034, 16'h00BF, 16'h0034,
      1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'd1, 1'b1, 2'd2, 8'd5, 8'h7F, 8'h7F, 8'h9D, 8'h40,
      8'h7F, 8'h12, 8'h9D, 8'h00, 16'h7F9D, 16'h7F40, 16'h7F9D, 16'h7F40,
      1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 2'd2, 1'b0, 2'd0, 8'd0, 8'h21, 8'hAB, 8'h00, 8'h00,
      8'h21, 8'hAB, 8'h00, 8'h00, 16'h0021, 16'h00AC, 16'h0021, 16'h00AB,
      1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 2'd0, 1'b1, 2'd1, 8'd0, 8'h7F, 8'h5A, 8'h7F, 8'h00,
      8'h00, 8'h5A, 8'h00, 8'h00, 16'h7F7F, 16'h005B, 16'h7F7F, 16'h005A,
      1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 1'b0, 2'd3, 8'd0, 8'hC2, 8'h7F, 8'h00, 8'h01,
      8'hFF, 8'hFF, 8'h00, 8'h00, 16'h00C2, 16'h7F01, 16'h00C2, 16'h7F01,
      1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          cfg_shifted;
  logic [1:0]    cfg_mask_sel;
  logic          cfg_long_reset;
  logic [1:0]    cfg_tmode;
  logic [DW-1:0] cfg_tval;
  logic [15:0]   exp_man, exp_dev;
  logic          bus_req, bus_we, bus_ack;
  logic [15:0]   bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          busy, done, id_match, parity_err, man_is_array, dev_is_array;
  logic [15:0]   id_man, id_dev;

  always #10 clk = ~clk;

  flash_id_probe #(
    .DLY_W(DW), .ENT_DEF(ENT), .EXT_DEF(EXT), .GAP_CYC(GAP)
  ) u_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_shifted(cfg_shifted), .cfg_mask_sel(cfg_mask_sel),
    .cfg_long_reset(cfg_long_reset), .cfg_tmode(cfg_tmode), .cfg_tval(cfg_tval),
    .exp_man(exp_man), .exp_dev(exp_dev),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .id_man(id_man), .id_dev(id_dev),
    .id_match(id_match), .parity_err(parity_err),
    .man_is_array(man_is_array), .dev_is_array(dev_is_array)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] cmd_adr(input logic sh, input logic [1:0] ms,
                                          input logic second);
    logic [15:0] m;
    m = (ms == 2'd1) ? 16'h07FF : (ms == 2'd2) ? 16'h0FFF : 16'hFFFF;
    return ((sh ^ second) ? 16'h2AAA : 16'h5555) & m;
  endfunction

  // behavioural flash model
  vec_t        cur;
  logic        idmode;
  logic [23:0] h1, h2;
  int          lg_n;
  logic        lg_we   [LGN];
  logic [15:0] lg_addr [LGN];
  logic [7:0]  lg_data [LGN];
  int          lg_cyc  [LGN];
  logic [15:0] ma1, ma2, moff;

  assign ma1  = cmd_adr(cur.sh, cur.ms, 1'b0);
  assign ma2  = cmd_adr(cur.sh, cur.ms, 1'b1);
  assign moff = cur.sh ? 16'd2 : 16'd1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 8'h00;
      idmode    <= 1'b0;
      h1        <= '0;
      h2        <= '0;
      lg_n      <= 0;
    end else begin
      if (bus_req && bus_ack) begin
        if (lg_n < LGN) begin
          lg_we[lg_n]   <= bus_we;
          lg_addr[lg_n] <= bus_addr;
          lg_data[lg_n] <= bus_we ? bus_wdata : bus_rdata;
          lg_cyc[lg_n]  <= cyc;
        end
        lg_n <= lg_n + 1;
        if (bus_we) begin
          if (bus_wdata == 8'hF0) idmode <= 1'b0;
          else if (bus_wdata == 8'h90 && bus_addr == ma1 &&
                   h2 == {ma1, 8'hAA} && h1 == {ma2, 8'h55}) idmode <= 1'b1;
          h2 <= h1;
          h1 <= {bus_addr, bus_wdata};
        end
      end
      bus_ack <= bus_req && !bus_ack;
      if (idmode) begin
        if (bus_addr == 16'h0000)      bus_rdata <= cur.i0;
        else if (bus_addr == moff)     bus_rdata <= cur.i1;
        else if (bus_addr == 16'h0100) bus_rdata <= cur.c0;
        else if (bus_addr == 16'h0101) bus_rdata <= cur.c1;
        else                           bus_rdata <= 8'h00;
      end else begin
        if (bus_addr == 16'h0000)                              bus_rdata <= cur.a0;
        else if (bus_addr == 16'h0001 || bus_addr == 16'h0002) bus_rdata <= cur.a1;
        else if (bus_addr == 16'h0100)                         bus_rdata <= cur.a100;
        else if (bus_addr == 16'h0101)                         bus_rdata <= cur.a101;
        else                                                   bus_rdata <= 8'hFF;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected bus trace
  int          e_n;
  logic        e_we  [32];
  logic [15:0] e_a   [32];
  logic [7:0]  e_d   [32];
  int          e_p   [32];

  task automatic add_op(input logic we, input logic [15:0] a, input logic [7:0] d,
                        input int p);
    e_we[e_n] = we; e_a[e_n] = a; e_d[e_n] = d; e_p[e_n] = p;
    e_n++;
  endtask

  task automatic build_exp(input vec_t v, input int ent, input int ext);
    logic [15:0] a1, a2, off;
    int ge, gx;
    a1  = cmd_adr(v.sh, v.ms, 1'b0);
    a2  = cmd_adr(v.sh, v.ms, 1'b1);
    off = v.sh ? 16'd2 : 16'd1;
    ge  = (ent != 0) ? GAP : 0;
    gx  = (ext != 0) ? GAP : 0;
    e_n = 0;
    if (v.lg) begin add_op(1, a1, 8'hAA, gx); add_op(1, a2, 8'h55, gx); end
    add_op(1, a1, 8'hF0, ext);
    add_op(1, a1, 8'hAA, ge);
    add_op(1, a2, 8'h55, ge);
    add_op(1, a1, 8'h90, ent);
    add_op(0, 16'h0000, 8'h00, -1);
    add_op(0, off, 8'h00, -1);
    if (v.i0 == 8'h7F) add_op(0, 16'h0100, 8'h00, -1);
    if (v.i1 == 8'h7F) add_op(0, 16'h0101, 8'h00, -1);
    if (v.lg) begin add_op(1, a1, 8'hAA, gx); add_op(1, a2, 8'h55, gx); end
    add_op(1, a1, 8'hF0, ext);
    add_op(0, 16'h0000, 8'h00, -1);
    add_op(0, off, 8'h00, -1);
    if (v.a0 == 8'h7F) add_op(0, 16'h0100, 8'h00, -1);
    if (v.a1 == 8'h7F) add_op(0, 16'h0101, 8'h00, -1);
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int ent, ext, base, s_cyc, n, cnt, bad;
    logic [15:0] hold_m;
    cur            = v;
    cfg_shifted    = v.sh;
    cfg_mask_sel   = v.ms;
    cfg_long_reset = v.lg;
    cfg_tmode      = v.tm;
    cfg_tval       = DW'(v.tv);
    exp_man        = v.em;
    exp_dev        = v.ed;
    ent = (v.tm == 2'd1) ? 0 : (v.tm == 2'd2) ? int'(v.tv) : ENT;
    ext = (v.tm == 2'd1) ? 0 : (v.tm == 2'd2) ? int'(v.tv) : EXT;
    build_exp(v, ent, ext);
    @(negedge clk);
    base  = lg_n;
    s_cyc = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
      start = (poke && (n == 30 || n == 60));
    end
    start = 1'b0;
    check(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
    check(busy == 1'b0, "R10 idle at done", 32'(busy), 32'd0);
    check(id_man == v.xm, "R4 manufacturer id", 32'(id_man), 32'(v.xm));
    check(id_dev == v.xd, "R4 device id", 32'(id_dev), 32'(v.xd));
    check(id_match == v.xmatch, "R8 match", 32'(id_match), 32'(v.xmatch));
    check(parity_err == v.xpar, "R7 parity", 32'(parity_err), 32'(v.xpar));
    check(man_is_array == v.xma, "R9 man array", 32'(man_is_array), 32'(v.xma));
    check(dev_is_array == v.xda, "R9 dev array", 32'(dev_is_array), 32'(v.xda));
    hold_m = id_man;
    @(negedge clk);
    check(done == 1'b0, "R10 single pulse", 32'(done), 32'd0);
    cnt = lg_n;
    repeat (6) @(negedge clk);
    check(lg_n == cnt && !busy, "R11 no restart", 32'(lg_n), 32'(cnt));
    check(id_man == hold_m, "R10 results held", 32'(id_man), 32'(hold_m));
    check(lg_n - base == e_n, "R3 op count", 32'(lg_n - base), 32'(e_n));
    if (lg_n - base == e_n) begin
      bad = 0;
      for (int i = 0; i < e_n; i++) begin
        if (lg_we[base+i] != e_we[i] || lg_addr[base+i] != e_a[i] ||
            (e_we[i] && lg_data[base+i] != e_d[i])) begin
          if (bad == 0)
            $display("FAIL R2 R3 op %0d actual %0h/%0h expected %0h/%0h", i,
                     lg_addr[base+i], lg_data[base+i], e_a[i], e_d[i]);
          bad++;
        end
      end
      checks++;
      if (bad != 0) errors++;
      for (int i = 1; i < e_n; i++) begin
        if (e_p[i-1] >= 0)
          check(lg_cyc[base+i] - lg_cyc[base+i-1] == e_p[i-1] + 2, "R5 R6 spacing",
                32'(lg_cyc[base+i] - lg_cyc[base+i-1]), 32'(e_p[i-1] + 2));
      end
      check(lg_cyc[base] - s_cyc == ent + (v.lg ? 3 : 5), "R5 entry lead",
            32'(lg_cyc[base] - s_cyc), 32'(ent + (v.lg ? 3 : 5)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cur = VT[0];
    cfg_shifted = 1'b0; cfg_mask_sel = 2'd0; cfg_long_reset = 1'b0;
    cfg_tmode = 2'd0; cfg_tval = '0; exp_man = '0; exp_dev = '0;
    repeat (4) @(negedge clk);
    check(!bus_req && !busy && !done, "R1 reset outputs",
          {29'd0, bus_req, busy, done}, 32'd0);
    check(id_man == 16'h0 && id_dev == 16'h0, "R1 reset ids",
          {id_man, id_dev}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!bus_req && !busy && !done, "R1 after release",
          {29'd0, bus_req, busy, done}, 32'd0);
    for (int k = 0; k < NV; k++) run_vec(VT[k], 1'b0);
    run_vec(VT[1], 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule